// File: doc/BRIEF.md
# Transmit Request Prioritizer

This block decides which pending outgoing message is handed to the CAN protocol engine next. It has two kinds of sources. The first is a set of transmit FIFOs. Each FIFO raises a request and carries a 5-bit priority. The second is a transmit queue with a few slots. Each slot holds a message identifier. Within the queue the slot with the numerically lowest identifier is offered, whatever order the slots were filled in. The whole queue then competes against the FIFOs using one programmable priority of its own.

The winner goes out on a valid/ready stream as a source flag and an index. The index is a FIFO number or a queue slot. The block evaluates a new winner only while it is idle. Once it makes an offer, it holds that offer stable while `sel_ready` is low. The offer is withdrawn, with valid falling in the same cycle, only if the offered source drops its request. A transfer takes place in a cycle where both valid and ready are high. After a transfer the block waits for a one-cycle result pulse from the engine: success or failure. It makes no new offer until that pulse arrives.

Each source has its own failed-attempt count. The retry policy allows a single attempt, three attempts, or unlimited attempts. When a source runs out of attempts, the block emits a one-cycle exhaustion pulse that names the source. It then skips that source until the source lowers its request.

Top module: `tx_request_prioritizer`

## Requirements
- R1: Among FIFOs that are requesting and not blocked, the FIFO with the highest `fifo_prio` value wins. Priority for FIFO i is held in `fifo_prio[5*i+4:5*i]`. On equal priority the lower FIFO number wins.
- R2: Among queue slots that are valid and not blocked, the slot with the lowest key wins. Identifier for slot j is `txq_id[29*j+28:29*j]`. An extended slot (`txq_ext[j]`=1) uses all 29 bits. A standard slot uses bits 10:0 shifted up by 18 places. When the 29-bit values are equal, a standard slot beats an extended one. When keys are fully equal, the lower slot wins.
- R3: The queue candidate beats the best FIFO only when `txq_prio` is strictly greater than that FIFO's priority. On equal priority the FIFO wins.
- R4: An offer becomes visible on `sel_valid` one cycle after a candidate appears while the block is idle. While ready is low, the offer's index and source do not change, even if a better request arrives. Valid falls in the same cycle the offered source drops its request. A new winner is chosen after that.
- R5: After a transfer, `sel_valid` stays low until a result pulse arrives. `res_ok` and `res_fail` have no effect outside that waiting period.
- R6: With `retry_mode`=00, the first failure exhausts the source.
- R7: With `retry_mode`=01, the third failure exhausts the source. A success resets that source's count to zero.
- R8: With `retry_mode`=1x, no number of failures exhausts a source.
- R9: Exhaustion raises `exhaust_valid` for exactly one cycle, in the cycle after the failing result. `exhaust_from_txq` and `exhaust_index` name the source. That source is then never offered until its request goes low.
- R10: During and right after reset, `sel_valid` and `exhaust_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_req | input | NUM_FIFO | Pending request per transmit FIFO |
| fifo_prio | input | NUM_FIFO*PRIO_W | Priority per FIFO, packed |
| txq_valid | input | TXQ_SLOTS | Occupied queue slots |
| txq_id | input | TXQ_SLOTS*29 | Identifier per slot, packed |
| txq_ext | input | TXQ_SLOTS | Extended-identifier flag per slot |
| txq_prio | input | PRIO_W | Priority of the queue as a whole |
| retry_mode | input | 2 | 00 single attempt, 01 three attempts, 1x unlimited |
| sel_valid | output | 1 | Offer present |
| sel_ready | input | 1 | Engine idle and ready to accept |
| sel_from_txq | output | 1 | Offer comes from the queue |
| sel_index | output | IDX_W | FIFO number or queue slot of the offer |
| res_ok | input | 1 | Accepted frame went out |
| res_fail | input | 1 | Accepted frame lost arbitration or hit an error |
| exhaust_valid | output | 1 | Attempt limit reached, pulse |
| exhaust_from_txq | output | 1 | Exhausted source is a queue slot |
| exhaust_index | output | IDX_W | FIFO number or slot that was exhausted |

## Verification
The bench goes after ties at every level:
- equal FIFO priorities, where a design that scans the wrong way picks the higher number;
- equal queue and FIFO priority, where the queue could wrongly win;
- a standard and an extended identifier with the same base, where a design that forgets to align standard IDs, or drops the format bit, picks the extended slot.

It raises a better request while an offer is pending. A design that re-evaluates at that point changes the payload under back-pressure. It also pulses results outside the waiting period and mixes successes into failure runs. An attempt counter that listens at the wrong time, or that is never cleared, exhausts a source too early. Last, it checks that an exhausted source is skipped in favour of a lower-priority one, and that it comes back once its request is cycled.

// File: rtl/txp_pkg.sv
package txp_pkg;

  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int KEY_W = ID_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2
  } txp_state_e;

  localparam logic [1:0] RM_SINGLE = 2'b00;
  localparam logic [1:0] RM_THREE  = 2'b01;

  // Comparison key: identifier aligned to 29 bits, format bit as LSB so a
  // standard frame sorts ahead of an extended one with the same base.
  function automatic logic [KEY_W-1:0] txp_key(input logic [ID_W-1:0] id,
                                               input logic ext);
    if (ext) return {id, 1'b1};
    return {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}, 1'b0};
  endfunction

endpackage

// File: rtl/txp_fifo_pick.sv
module txp_fifo_pick #(
  parameter int NF = 8,
  parameter int PW = 5,
  parameter int IW = 3
) (
  input  logic [NF-1:0]    req,
  input  logic [NF*PW-1:0] prio,
  input  logic [NF-1:0]    blk,
  output logic             found,
  output logic [IW-1:0]    idx,
  output logic [PW-1:0]    best
);

  // Ascending scan with strict compare keeps the lowest number on a tie.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NF; i++) begin
      if (req[i] && !blk[i] && (!found || prio[i*PW +: PW] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end

endmodule

// File: rtl/txp_txq_pick.sv
module txp_txq_pick
  import txp_pkg::*;
#(
  parameter int TQ = 4,
  parameter int IW = 3
) (
  input  logic [TQ-1:0]      valid,
  input  logic [TQ*ID_W-1:0] ids,
  input  logic [TQ-1:0]      ext,
  input  logic [TQ-1:0]      blk,
  output logic               found,
  output logic [IW-1:0]      idx
);

  logic [KEY_W-1:0] keys [TQ];

  for (genvar j = 0; j < TQ; j++) begin : g_key
    assign keys[j] = txp_key(ids[j*ID_W +: ID_W], ext[j]);
  end

  logic [KEY_W-1:0] best_key;

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_key = '0;
    for (int j = 0; j < TQ; j++) begin
      if (valid[j] && !blk[j] && (!found || keys[j] < best_key)) begin
        found    = 1'b1;
        idx      = IW'(j);
        best_key = keys[j];
      end
    end
  end

endmodule

// File: rtl/txp_retry.sv
module txp_retry
  import txp_pkg::*;
#(
  parameter int NS = 12,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] req,
  input  logic [1:0]    mode,
  input  logic          res_ok,
  input  logic          res_fail,
  input  logic [SW-1:0] cur,
  output logic [NS-1:0] blk,
  output logic          exh,
  output logic [SW-1:0] exh_src
);

  logic       unlimited;
  logic [1:0] limit;
  logic [NS-1:0] fire;

  assign unlimited = mode[1];
  assign limit     = (mode == RM_SINGLE) ? 2'd1 : 2'd3;

  for (genvar s = 0; s < NS; s++) begin : g_src
    logic [1:0] cnt;
    logic       blocked;
    logic       hit;

    assign hit     = (cur == SW'(s));
    assign fire[s] = hit && res_fail && req[s] && !unlimited &&
                     ((cnt + 2'd1) == limit);
    assign blk[s]  = blocked;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt     <= '0;
        blocked <= 1'b0;
      end else if (!req[s]) begin
        cnt     <= '0;
        blocked <= 1'b0;
      end else if (hit && res_ok) begin
        cnt <= '0;
      end else if (fire[s]) begin
        cnt     <= '0;
        blocked <= 1'b1;
      end else if (hit && res_fail && !unlimited) begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exh     <= 1'b0;
      exh_src <= '0;
    end else begin
      exh     <= |fire;
      exh_src <= cur;
    end
  end

endmodule

// File: rtl/tx_request_prioritizer.sv
module tx_request_prioritizer
  import txp_pkg::*;
#(
  parameter int NUM_FIFO  = 8,
  parameter int TXQ_SLOTS = 4,
  parameter int PRIO_W    = 5,
  localparam int MAX_N    = (NUM_FIFO > TXQ_SLOTS) ? NUM_FIFO : TXQ_SLOTS,
  localparam int IDX_W    = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_FIFO-1:0]         fifo_req,
  input  logic [NUM_FIFO*PRIO_W-1:0]  fifo_prio,
  input  logic [TXQ_SLOTS-1:0]        txq_valid,
  input  logic [TXQ_SLOTS*ID_W-1:0]   txq_id,
  input  logic [TXQ_SLOTS-1:0]        txq_ext,
  input  logic [PRIO_W-1:0]           txq_prio,
  input  logic [1:0]                  retry_mode,
  output logic                        sel_valid,
  input  logic                        sel_ready,
  output logic                        sel_from_txq,
  output logic [IDX_W-1:0]            sel_index,
  input  logic                        res_ok,
  input  logic                        res_fail,
  output logic                        exhaust_valid,
  output logic                        exhaust_from_txq,
  output logic [IDX_W-1:0]            exhaust_index
);

  localparam int NS = NUM_FIFO + TXQ_SLOTS;
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;

  logic [NS-1:0] req_vec, blk;
  assign req_vec = {txq_valid, fifo_req};

  // FIFO candidate
  logic              f_found;
  logic [IDX_W-1:0]  f_idx;
  logic [PRIO_W-1:0] f_best;

  txp_fifo_pick #(.NF(NUM_FIFO), .PW(PRIO_W), .IW(IDX_W)) i_fifo_pick (
    .req   (fifo_req),
    .prio  (fifo_prio),
    .blk   (blk[NUM_FIFO-1:0]),
    .found (f_found),
    .idx   (f_idx),
    .best  (f_best)
  );

  // Queue candidate
  logic             q_found;
  logic [IDX_W-1:0] q_idx;

  txp_txq_pick #(.TQ(TXQ_SLOTS), .IW(IDX_W)) i_txq_pick (
    .valid (txq_valid),
    .ids   (txq_id),
    .ext   (txq_ext),
    .blk   (blk[NS-1:NUM_FIFO]),
    .found (q_found),
    .idx   (q_idx)
  );

  // Final merge: queue wins only on strictly higher priority
  logic             win_any, win_txq;
  logic [IDX_W-1:0] win_idx;
  logic [SW-1:0]    win_src;

  assign win_txq = q_found && (!f_found || txq_prio > f_best);
  assign win_any = f_found || q_found;
  assign win_idx = win_txq ? q_idx : f_idx;
  assign win_src = win_txq ? SW'(NUM_FIFO) + SW'(q_idx) : SW'(f_idx);

  // Offer / wait state machine
  txp_state_e       state;
  logic             cur_txq;
  logic [IDX_W-1:0] cur_idx;
  logic [SW-1:0]    cur_src;
  logic             cur_req;

  assign cur_req = req_vec[cur_src];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_txq <= 1'b0;
      cur_idx <= '0;
      cur_src <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (win_any) begin
          state   <= ST_OFFER;
          cur_txq <= win_txq;
          cur_idx <= win_idx;
          cur_src <= win_src;
        end
        ST_OFFER: begin
          if (!cur_req)       state <= ST_IDLE;
          else if (sel_ready) state <= ST_BUSY;
        end
        ST_BUSY: if (res_ok || res_fail) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_valid    = (state == ST_OFFER) && cur_req;
  assign sel_from_txq = cur_txq;
  assign sel_index    = cur_idx;

  // Attempt tracking
  logic          busy;
  logic          exh;
  logic [SW-1:0] exh_src;

  assign busy = (state == ST_BUSY);

  txp_retry #(.NS(NS), .SW(SW)) i_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_vec),
    .mode     (retry_mode),
    .res_ok   (res_ok && busy),
    .res_fail (res_fail && busy),
    .cur      (cur_src),
    .blk      (blk),
    .exh      (exh),
    .exh_src  (exh_src)
  );

  assign exhaust_valid    = exh;
  assign exhaust_from_txq = (exh_src >= SW'(NUM_FIFO));
  assign exhaust_index    = exhaust_from_txq ? IDX_W'(exh_src - SW'(NUM_FIFO))
                                             : IDX_W'(exh_src);

endmodule

// File: rtl/tx_request_prioritizer_chk.sv
module tx_request_prioritizer_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_valid,
  input logic             sel_ready,
  input logic             sel_from_txq,
  input logic [IDX_W-1:0] sel_index,
  input logic             res_fail,
  input logic [1:0]       retry_mode,
  input logic             exhaust_valid
);

  // R4: payload is held while the offer waits on ready
  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && !sel_ready |=>
      !sel_valid || ($stable(sel_index) && $stable(sel_from_txq)));

  // R5: no new offer directly after a transfer
  a_r5_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && sel_ready |=> !sel_valid);

  // R9: exhaustion is a single-cycle pulse
  a_r9_exhaust_single: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_valid |=> !exhaust_valid);

  // R9: exhaustion only follows a failure report
  a_r9_exhaust_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_valid |-> $past(res_fail));

  // R8: unlimited policy never exhausts
  a_r8_unlimited_never: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_valid |-> !$past(retry_mode[1]));

endmodule

bind tx_request_prioritizer tx_request_prioritizer_chk #(.IDX_W(IDX_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_valid     (sel_valid),
  .sel_ready     (sel_ready),
  .sel_from_txq  (sel_from_txq),
  .sel_index     (sel_index),
  .res_fail      (res_fail),
  .retry_mode    (retry_mode),
  .exhaust_valid (exhaust_valid)
);

// File: tb/test_tx_request_prioritizer.sv
module test_tx_request_prioritizer;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   fifo_req;
  logic [39:0]  fifo_prio;
  logic [3:0]   txq_valid;
  logic [115:0] txq_id;
  logic [3:0]   txq_ext;
  logic [4:0]   txq_prio;
  logic [1:0]   retry_mode;
  logic         sel_valid, sel_ready, sel_from_txq;
  logic [2:0]   sel_index;
  logic         res_ok, res_fail;
  logic         exhaust_valid, exhaust_from_txq;
  logic [2:0]   exhaust_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_request_prioritizer i_tx_request_prioritizer (.*);

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]   freq;
    logic [39:0]  fprio;
    logic [3:0]   tval;
    logic [115:0] tid;
    logic [3:0]   text;
    logic [4:0]   tprio;
    logic         ev;
    logic         etxq;
    logic [2:0]   eidx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R1: higher priority wins
    '{8'b00000101, {5'd0,5'd0,5'd0,5'd0,5'd0,5'd9,5'd0,5'd3}, 4'b0, 116'd0, 4'b0, 5'd0, 1'b1, 1'b0, 3'd2},
    // R1: tie goes to lower FIFO
    '{8'b00000101, {5'd0,5'd0,5'd0,5'd0,5'd0,5'd9,5'd0,5'd9}, 4'b0, 116'd0, 4'b0, 5'd0, 1'b1, 1'b0, 3'd0},
    // R1: top and near-top priority
    '{8'b10000010, {5'd31,5'd0,5'd0,5'd0,5'd0,5'd0,5'd30,5'd0}, 4'b0, 116'd0, 4'b0, 5'd0, 1'b1, 1'b0, 3'd7},
    // R2: lowest identifier, not slot order
    '{8'b0, 40'd0, 4'b1111, {29'h60, 29'h7FF, 29'h50, 29'h100}, 4'b1011, 5'd0, 1'b1, 1'b1, 3'd1},
    // R2: standard beats extended with same base
    '{8'b0, 40'd0, 4'b0101, {29'h0, 29'h123, 29'h0, 29'h48C0000}, 4'b0001, 5'd0, 1'b1, 1'b1, 3'd2},
    // R3: queue priority higher
    '{8'b00001000, {5'd0,5'd0,5'd0,5'd0,5'd10,5'd0,5'd0,5'd0}, 4'b0001, {87'd0, 29'h5}, 4'b0001, 5'd11, 1'b1, 1'b1, 3'd0},
    // R3: equal priority, FIFO wins
    '{8'b00001000, {5'd0,5'd0,5'd0,5'd0,5'd10,5'd0,5'd0,5'd0}, 4'b0001, {87'd0, 29'h5}, 4'b0001, 5'd10, 1'b1, 1'b0, 3'd3},
    // R2: equal keys, lower slot
    '{8'b0, 40'd0, 4'b1010, {29'h20, 29'h0, 29'h20, 29'h0}, 4'b1010, 5'd0, 1'b1, 1'b1, 3'd1},
    // R4: nothing pending, no offer
    '{8'b0, 40'd0, 4'b0, 116'd0, 4'b0, 5'd0, 1'b0, 1'b0, 3'd0},
    // R3: zero priorities tie, FIFO wins
    '{8'b01000000, 40'd0, 4'b1000, 116'd0, 4'b1000, 5'd0, 1'b1, 1'b0, 3'd6}
  };

  task automatic clear_inputs();
    fifo_req = '0; fifo_prio = '0; txq_valid = '0; txq_id = '0;
    txq_ext = '0; txq_prio = '0;
  endtask

  task automatic wait_offer();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (sel_valid) break;
    end
  endtask

  // Accept current offer, report result, return exhaust outputs
  task automatic attempt(input bit fail, output logic ex, output logic ex_txq,
                         output logic [2:0] ex_idx);
    sel_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sel_ready = 1'b0;
    check("R5 no offer while waiting", sel_valid, 1'b0);
    @(negedge clk);
    check("R5 still waiting", sel_valid, 1'b0);
    res_fail = fail;
    res_ok   = !fail;
    @(posedge clk);
    @(negedge clk);
    res_fail = 1'b0;
    res_ok   = 1'b0;
    ex = exhaust_valid; ex_txq = exhaust_from_txq; ex_idx = exhaust_index;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic ex, ex_txq;
    logic [2:0] ex_idx;
    rst_n = 1'b0; sel_ready = 1'b0; res_ok = 1'b0; res_fail = 1'b0;
    retry_mode = 2'b00;
    clear_inputs();
    fifo_req = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset valid", sel_valid, 1'b0);
    check("R10 reset exhaust", exhaust_valid, 1'b0);
    clear_inputs();
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", sel_valid, 1'b0);

    // Vector table
    foreach (VECS[v]) begin
      @(negedge clk);
      fifo_req = VECS[v].freq; fifo_prio = VECS[v].fprio;
      txq_valid = VECS[v].tval; txq_id = VECS[v].tid;
      txq_ext = VECS[v].text; txq_prio = VECS[v].tprio;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R1/R2/R3 vec %0d valid", v), sel_valid, VECS[v].ev);
      if (VECS[v].ev) begin
        check($sformatf("R1/R2/R3 vec %0d source", v), sel_from_txq, VECS[v].etxq);
        check($sformatf("R1/R2/R3 vec %0d index", v), sel_index, VECS[v].eidx);
      end
      clear_inputs();
      @(posedge clk);
    end

    // R4: hold under back-pressure, withdraw, re-evaluate
    @(negedge clk);
    fifo_req = 8'b00000100; fifo_prio[10 +: 5] = 5'd5;
    @(posedge clk);
    @(negedge clk);
    check("R4 first offer", sel_index, 3'd2);
    fifo_req[5] = 1'b1; fifo_prio[25 +: 5] = 5'd20;
    @(posedge clk);
    @(negedge clk);
    check("R4 held index", sel_index, 3'd2);
    check("R4 held valid", sel_valid, 1'b1);
    fifo_req[2] = 1'b0;
    #1;
    check("R4 withdraw same cycle", sel_valid, 1'b0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R4 reevaluated index", sel_index, 3'd5);
    check("R4 reevaluated valid", sel_valid, 1'b1);
    clear_inputs();
    @(posedge clk);

    // R6 single attempt, then R9 skip and release
    retry_mode = 2'b00;
    @(negedge clk);
    fifo_req = 8'b00000001; fifo_prio[0 +: 5] = 5'd20;
    wait_offer();
    attempt(1'b1, ex, ex_txq, ex_idx);
    check("R6 exhaust on first fail", ex, 1'b1);
    check("R9 exhaust source", ex_txq, 1'b0);
    check("R9 exhaust index", ex_idx, 3'd0);
    @(negedge clk);
    check("R9 pulse one cycle", exhaust_valid, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 blocked not offered", sel_valid, 1'b0);
    fifo_req[1] = 1'b1; fifo_prio[5 +: 5] = 5'd1;
    wait_offer();
    check("R9 blocked skipped index", sel_index, 3'd1);
    clear_inputs();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    fifo_req = 8'b00000001; fifo_prio[0 +: 5] = 5'd20;
    wait_offer();
    check("R9 released after drop", sel_valid, 1'b1);
    check("R9 released index", sel_index, 3'd0);

    // R5 ignored results, then R7 three attempts with success reset
    retry_mode = 2'b01;
    for (int k = 0; k < 4; k++) begin
      res_fail = 1'b1; @(negedge clk);
    end
    res_fail = 1'b0;
    check("R5 offer kept after stray results", sel_valid, 1'b1);
    attempt(1'b1, ex, ex_txq, ex_idx); check("R7 fail 1", ex, 1'b0);
    wait_offer(); attempt(1'b1, ex, ex_txq, ex_idx); check("R7 fail 2", ex, 1'b0);
    wait_offer(); attempt(1'b0, ex, ex_txq, ex_idx); check("R7 success", ex, 1'b0);
    wait_offer(); attempt(1'b1, ex, ex_txq, ex_idx); check("R7 fail after reset 1", ex, 1'b0);
    wait_offer(); attempt(1'b1, ex, ex_txq, ex_idx); check("R7 fail after reset 2", ex, 1'b0);
    wait_offer(); attempt(1'b1, ex, ex_txq, ex_idx); check("R7 third fail exhausts", ex, 1'b1);
    clear_inputs();
    @(posedge clk);
    @(posedge clk);

    // R8 unlimited
    retry_mode = 2'b10;
    @(negedge clk);
    fifo_req = 8'b00010000; fifo_prio[20 +: 5] = 5'd7;
    for (int k = 0; k < 6; k++) begin
      wait_offer();
      attempt(1'b1, ex, ex_txq, ex_idx);
      check($sformatf("R8 fail %0d no exhaust", k), ex, 1'b0);
    end
    wait_offer();
    check("R8 still offered", sel_valid, 1'b1);
    clear_inputs();
    @(posedge clk);
    @(posedge clk);

    // R9 queue slot exhaustion naming
    retry_mode = 2'b00;
    @(negedge clk);
    txq_valid = 4'b0100; txq_id[58 +: 29] = 29'h9; txq_ext = 4'b0100; txq_prio = 5'd3;
    wait_offer();
    check("R2 single slot offered", sel_index, 3'd2);
    attempt(1'b1, ex, ex_txq, ex_idx);
    check("R9 queue exhaust", ex, 1'b1);
    check("R9 queue exhaust source", ex_txq, 1'b1);
    check("R9 queue exhaust slot", ex_idx, 3'd2);
    clear_inputs();
    @(posedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule